// File: doc/BRIEF.md
# Aliasing Bus Address Decoder

This block sits on a shared 16-bit CPU address bus and decides, for a small set of memory-mapped device slots, which of them take part in the current bus cycle. The address and the read and write strobes reach every slot at the same time. Each slot settles its own match without looking at any other slot. The match compares the address with the slot's base, but only on the bits that slot does not ignore. A slot carries two separate ignore masks, one for reads and one for writes, so the alias addresses at which it can be read may differ from those at which it can be written.

The block does not stop overlaps. Every slot that matches a write is selected, so one bus cycle can write several devices. The read data of every slot that matches a read is merged with a bitwise OR into the value returned to the CPU. A per-slot multiple-hit flag exposes these overlaps for debugging. A no-response flag marks a read that no slot answered.

Each slot also receives a local offset. This is the address cut down to the slot's window size, so an alias address reaches the same device location as the official address. The whole path is combinational. Slot count, bases, window sizes and both ignore masks are elaboration-time parameters.

Top module: `alias_bus_decoder`

## Requirements
- R1: Slot i decodes a read hit when ((addr XOR base) AND NOT (rd_ignore OR (2^ofs_bits - 1))) is zero. The bits inside its own window are never compared.
- R2: Write hits use the same rule with the slot's write ignore mask in place of the read one. An address can therefore hit a slot for reads and miss it for writes, or the reverse.
- R3: `rd_sel[i]` is 1 only while `bus_rd` is 1, and `wr_sel[i]` is 1 only while `bus_wr` is 1. With both strobes low, all selects, `multi_hit`, `cpu_rdata` and `no_resp` are 0.
- R4: While `bus_rd` is 1, `cpu_rdata` is the bitwise OR of `dev_rdata` field i (bits 16i+15..16i) over every slot i with `rd_sel[i]` set.
- R5: `no_resp` is 1 exactly when `bus_rd` is 1 and no slot read-matches, and `cpu_rdata` is then 0.
- R6: Field i of `dev_offset` (bits 16i+15..16i) equals addr AND (2^ofs_bits_i - 1), whatever the strobes are.
- R7: A write selects every slot whose write decode hits, and several `wr_sel` bits may be 1 together.
- R8: `multi_hit[i]` is 1 when slot i is read-selected while at least one other slot is read-selected, or slot i is write-selected while at least one other slot is write-selected.
- R9: The default map has four slots: slot0 base 0x1000, 12 offset bits, ignore 0x8000 for reads and for writes; slot1 base 0x2000, 8 offset bits, read ignore 0x0F00, write ignore 0; slot2 base 0x4000, 4 offset bits, read ignore 0x00F0, write ignore 0; slot3 base 0x4000, 8 offset bits, read ignore 0, write ignore 0x8000. Slot0 therefore answers at 0x1000-0x1FFF and at 0x9000-0x9FFF, and 0x9000 gives offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 16 | CPU address broadcast to all slots |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| dev_rdata | input | 16*NSLOT | Read data of each device, slot i in bits 16i+15..16i |
| rd_sel | output | NSLOT | Per-slot read select |
| wr_sel | output | NSLOT | Per-slot write select |
| dev_offset | output | 16*NSLOT | Local offset for each slot, slot i in bits 16i+15..16i |
| cpu_rdata | output | 16 | Merged read data returned to the CPU |
| no_resp | output | 1 | Read cycle that no slot answered |
| multi_hit | output | NSLOT | Slot shares the current read or write with another slot |

## Verification
The bench sweeps all 65536 addresses with both strobes on and predicts every output from the map in R9, so it catches a decoder that compares offset bits, which would leave mirrors missing, or one that swaps the read and write masks, which would show as a wrong select around 0x2100 and 0xC000. The overlapping slot pair at 0x4000 tests the OR merge and the multiple-hit flags; a priority mux in place of the OR would lose bits from one device. Sweeps with the strobes low or on one side only catch selects that are not gated by their own strobe. The holes in the map catch a `no_resp` that is inverted or left stuck.

// File: rtl/alias_dec_pkg.sv
package alias_dec_pkg;

  localparam int ADDR_W = 16;

  typedef logic [ADDR_W-1:0] addr_t;

  // window mask for a slot holding 2^bits words
  function automatic addr_t win_mask(input int bits);
    addr_t m;
    m = '0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b < bits) m[b] = 1'b1;
    end
    return m;
  endfunction

  // incomplete decode: compare only the bits nobody ignores
  function automatic logic addr_hit(input addr_t a, input addr_t base,
                                    input addr_t dont_care);
    return ((a ^ base) & ~dont_care) == '0;
  endfunction

endpackage

// File: rtl/alias_slot.sv
module alias_slot
  import alias_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE     = 16'h1000,
  parameter int                OFS_BITS = 12,
  parameter logic [ADDR_W-1:0] RD_IGN   = 16'h0000,
  parameter logic [ADDR_W-1:0] WR_IGN   = 16'h0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              rd_sel_o,
  output logic              wr_sel_o,
  output logic [ADDR_W-1:0] offset_o
);

  localparam addr_t WIN     = win_mask(OFS_BITS);
  localparam addr_t RD_DC   = RD_IGN | WIN;
  localparam addr_t WR_DC   = WR_IGN | WIN;

  logic rd_match;
  logic wr_match;

  always_comb begin
    rd_match = addr_hit(addr_i, BASE, RD_DC);
    wr_match = addr_hit(addr_i, BASE, WR_DC);
    rd_sel_o = rd_i & rd_match;
    wr_sel_o = wr_i & wr_match;
    offset_o = addr_i & WIN;
  end

  always_comb begin
    p_rd_gated_r3: assert (!rd_sel_o || rd_i)
      else $error("read select without read strobe");
    p_wr_gated_r3: assert (!wr_sel_o || wr_i)
      else $error("write select without write strobe");
    p_offset_window_r6: assert ((offset_o & ~WIN) == '0)
      else $error("offset leaves the slot window");
  end

endmodule

// File: rtl/rd_merge.sv
module rd_merge #(
  parameter int NSLOT = 4,
  parameter int DW    = 16
) (
  input  logic [NSLOT-1:0]    sel_i,
  input  logic [NSLOT*DW-1:0] data_i,
  input  logic                rd_i,
  output logic [DW-1:0]       rdata_o,
  output logic                no_resp_o
);

  logic [DW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (sel_i[s]) acc = acc | data_i[s*DW +: DW];
    end
    rdata_o   = acc;
    no_resp_o = rd_i & ~(|sel_i);
  end

  always_comb begin
    p_noresp_quiet_r5: assert (!no_resp_o || rdata_o == '0)
      else $error("data returned on an unanswered read");
    p_noresp_excl_r5: assert (!(no_resp_o && |sel_i))
      else $error("no-response flag while a slot answers");
  end

endmodule

// File: rtl/hit_overlap.sv
module hit_overlap #(
  parameter int NSLOT = 4
) (
  input  logic [NSLOT-1:0] rd_sel_i,
  input  logic [NSLOT-1:0] wr_sel_i,
  output logic [NSLOT-1:0] multi_o
);

  localparam int CW = $clog2(NSLOT + 1);

  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] wr_cnt;
  logic          rd_many;
  logic          wr_many;

  always_comb begin
    rd_cnt = '0;
    wr_cnt = '0;
    for (int s = 0; s < NSLOT; s++) begin
      rd_cnt = rd_cnt + CW'(rd_sel_i[s]);
      wr_cnt = wr_cnt + CW'(wr_sel_i[s]);
    end
    rd_many = rd_cnt > CW'(1);
    wr_many = wr_cnt > CW'(1);
    multi_o = ({NSLOT{rd_many}} & rd_sel_i) | ({NSLOT{wr_many}} & wr_sel_i);
  end

  always_comb begin
    p_single_quiet_r8: assert (!($onehot0(rd_sel_i) && $onehot0(wr_sel_i)) || multi_o == '0)
      else $error("overlap flagged with at most one hit per direction");
    p_multi_is_hit_r8: assert ((multi_o & ~(rd_sel_i | wr_sel_i)) == '0)
      else $error("overlap flagged on an idle slot");
  end

endmodule

// File: rtl/alias_bus_decoder.sv
module alias_bus_decoder
  import alias_dec_pkg::*;
#(
  parameter int                    NSLOT     = 4,
  parameter int                    DW        = 16,
  parameter logic [NSLOT*16-1:0]   SLOT_BASE = {16'h4000, 16'h4000, 16'h2000, 16'h1000},
  parameter logic [NSLOT*5-1:0]    SLOT_OFSB = {5'd8, 5'd4, 5'd8, 5'd12},
  parameter logic [NSLOT*16-1:0]   SLOT_RIGN = {16'h0000, 16'h00F0, 16'h0F00, 16'h8000},
  parameter logic [NSLOT*16-1:0]   SLOT_WIGN = {16'h8000, 16'h0000, 16'h0000, 16'h8000}
) (
  input  logic [15:0]         bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [NSLOT*DW-1:0] dev_rdata,
  output logic [NSLOT-1:0]    rd_sel,
  output logic [NSLOT-1:0]    wr_sel,
  output logic [NSLOT*16-1:0] dev_offset,
  output logic [DW-1:0]       cpu_rdata,
  output logic                no_resp,
  output logic [NSLOT-1:0]    multi_hit
);

  logic [DW-1:0] merged;
  logic          unanswered;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [15:0] B  = SLOT_BASE[g*16 +: 16];
    localparam int          OB = int'(SLOT_OFSB[g*5 +: 5]);
    localparam logic [15:0] RI = SLOT_RIGN[g*16 +: 16];
    localparam logic [15:0] WI = SLOT_WIGN[g*16 +: 16];

    alias_slot #(
      .BASE    (B),
      .OFS_BITS(OB),
      .RD_IGN  (RI),
      .WR_IGN  (WI)
    ) i_slot (
      .addr_i  (bus_addr),
      .rd_i    (bus_rd),
      .wr_i    (bus_wr),
      .rd_sel_o(rd_sel[g]),
      .wr_sel_o(wr_sel[g]),
      .offset_o(dev_offset[g*16 +: 16])
    );
  end

  rd_merge #(
    .NSLOT(NSLOT),
    .DW   (DW)
  ) i_merge (
    .sel_i    (rd_sel),
    .data_i   (dev_rdata),
    .rd_i     (bus_rd),
    .rdata_o  (merged),
    .no_resp_o(unanswered)
  );

  hit_overlap #(
    .NSLOT(NSLOT)
  ) i_overlap (
    .rd_sel_i(rd_sel),
    .wr_sel_i(wr_sel),
    .multi_o (multi_hit)
  );

  assign cpu_rdata = merged;
  assign no_resp   = unanswered;

  always_comb begin
    p_idle_quiet_r3: assert (bus_rd || (cpu_rdata == '0 && !no_resp))
      else $error("read outputs active without read strobe");
    p_answer_or_flag_r5: assert (!bus_rd || no_resp || rd_sel != '0)
      else $error("read neither answered nor flagged");
  end

endmodule

// File: tb/test_alias_bus_decoder.sv
module test_alias_bus_decoder;

  localparam int NSLOT      = 4;
  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic [15:0]         bus_addr = '0;
  logic                bus_rd = 1'b0;
  logic                bus_wr = 1'b0;
  logic [NSLOT*16-1:0] dev_rdata;
  logic [NSLOT-1:0]    rd_sel, wr_sel, multi_hit;
  logic [NSLOT*16-1:0] dev_offset;
  logic [15:0]         cpu_rdata;
  logic                no_resp;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_bus_decoder i_alias_bus_decoder (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .dev_rdata (dev_rdata),
    .rd_sel    (rd_sel),
    .wr_sel    (wr_sel),
    .dev_offset(dev_offset),
    .cpu_rdata (cpu_rdata),
    .no_resp   (no_resp),
    .multi_hit (multi_hit)
  );

  // device i returns its own bit plus the low address byte in the upper byte
  function automatic logic [15:0] dev_word(int s, logic [15:0] a);
    return (16'h0001 << s) | {a[7:0], 8'h00};
  endfunction

  always_comb begin
    for (int s = 0; s < NSLOT; s++) dev_rdata[s*16 +: 16] = dev_word(s, bus_addr);
  end

  // reference map from R9
  function automatic bit ref_hit(int s, logic [15:0] a, bit wr);
    logic [15:0] b, dc;
    case (s)
      0:       begin b = 16'h1000; dc = 16'h8FFF; end
      1:       begin b = 16'h2000; dc = wr ? 16'h00FF : 16'h0FFF; end
      2:       begin b = 16'h4000; dc = wr ? 16'h000F : 16'h00FF; end
      default: begin b = 16'h4000; dc = wr ? 16'h80FF : 16'h00FF; end
    endcase
    return ((a ^ b) & ~dc) == 16'h0;
  endfunction

  function automatic logic [15:0] ref_win(int s);
    case (s)
      0: return 16'h0FFF;
      1: return 16'h00FF;
      2: return 16'h000F;
      default: return 16'h00FF;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h rd %b wr %b)",
               req, act, exp, bus_addr, bus_rd, bus_wr);
    end
  endtask

  task automatic check_all();
    logic [NSLOT-1:0] er, ew, em;
    logic [NSLOT*16-1:0] eo;
    logic [15:0] ed;
    int cr, cw;
    er = '0; ew = '0; ed = '0; cr = 0; cw = 0;
    for (int s = 0; s < NSLOT; s++) begin
      er[s] = bus_rd && ref_hit(s, bus_addr, 1'b0);
      ew[s] = bus_wr && ref_hit(s, bus_addr, 1'b1);
      eo[s*16 +: 16] = bus_addr & ref_win(s);
      if (er[s]) begin ed = ed | dev_word(s, bus_addr); cr++; end
      if (ew[s]) cw++;
    end
    for (int s = 0; s < NSLOT; s++) em[s] = (er[s] && cr > 1) || (ew[s] && cw > 1);
    check("R1 rd_sel", 64'(rd_sel), 64'(er));
    check("R7 wr_sel", 64'(wr_sel), 64'(ew));
    check("R6 dev_offset", 64'(dev_offset), 64'(eo));
    check("R4 cpu_rdata", 64'(cpu_rdata), 64'(ed));
    check("R5 no_resp", 64'(no_resp), 64'(bus_rd && cr == 0));
    check("R8 multi_hit", 64'(multi_hit), 64'(em));
  endtask

  task automatic apply(logic [15:0] a, bit r, bit w);
    bus_addr = a; bus_rd = r; bus_wr = w;
    #1;
    check_all();
    #1;
  endtask

  initial begin
    @(negedge clk);
    // idle state: no strobes, nothing selected (R3)
    #1;
    check("R3 idle rd_sel", 64'(rd_sel), 64'h0);
    check("R3 idle wr_sel", 64'(wr_sel), 64'h0);
    check("R3 idle no_resp", 64'(no_resp), 64'h0);
    check("R3 idle cpu_rdata", 64'(cpu_rdata), 64'h0);

    // full sweep with both strobes: R1 R2 R4 R5 R6 R7 R8
    for (int a = 0; a < 65536; a++) apply(16'(a), 1'b1, 1'b1);

    // strobe gating sweeps: R3
    for (int a = 0; a < 65536; a += 16) apply(16'(a), 1'b0, 1'b0);
    for (int a = 0; a < 65536; a += 64) apply(16'(a), 1'b1, 1'b0);
    for (int a = 0; a < 65536; a += 64) apply(16'(a), 1'b0, 1'b1);

    // R2: read mirror of slot1 at 0x2500 is not writable
    bus_addr = 16'h2500; bus_rd = 1'b1; bus_wr = 1'b1; #1;
    check("R2 read mirror hit", 64'(rd_sel[1]), 64'h1);
    check("R2 write mirror miss", 64'(wr_sel[1]), 64'h0);
    // R2: write mirror of slot3 at 0xC010 is not readable
    bus_addr = 16'hC010; #1;
    check("R2 write alias hit", 64'(wr_sel), 64'h8);
    check("R2 read alias miss", 64'(rd_sel), 64'h0);
    check("R5 unanswered read", 64'(no_resp), 64'h1);

    // R9: 0x9000 reaches slot0 location 0
    bus_addr = 16'h9000; bus_wr = 1'b0; #1;
    check("R9 alias select", 64'(rd_sel), 64'h1);
    check("R9 alias offset", 64'(dev_offset[15:0]), 64'h0);
    check("R9 alias data", 64'(cpu_rdata), 64'h0001);
    bus_addr = 16'h1FFF; #1;
    check("R9 official top", 64'(dev_offset[15:0]), 64'hFFF);

    // R8 and R4: overlap at 0x4005
    bus_addr = 16'h4005; bus_wr = 1'b1; #1;
    check("R8 overlap flags", 64'(multi_hit), 64'hC);
    check("R4 merged data", 64'(cpu_rdata), 64'h050C);
    bus_rd = 1'b0; bus_wr = 1'b0; #1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule